// File: doc/BRIEF.md
# Coprocessor Response Primitive Sequencer

This block sits on the main-processor side of a coprocessor link and carries out two response primitives that the coprocessor may return during a general-category instruction. The first is a status transfer: it moves the 16-bit status register and, optionally, the 32-bit scan program counter between the processor and the coprocessor's interface registers, in either direction. The second is a take-exception primitive: it acknowledges the coprocessor and then asks the processor to start a pre-instruction exception with a vector number that the coprocessor supplies.

A primitive is offered with `prim_valid` and is taken when the sequencer is idle. The sequencer then issues interface-register accesses one at a time. Each access is held until the responder answers with `acc_done`. After an inbound status transfer it requests a prefetch flush and a refill. It also keeps a change-of-flow trace pending until the coprocessor reports that the instruction is complete. Bus cycles, stack frames and the other primitives are handled elsewhere.

Primitive word fields: bit 15 is the PC flag, bit 13 is the direction (1 = into the processor), bit 12 selects whether the scan PC takes part, and bits 7:0 carry the vector. `prim_exc` = 1 marks the take-exception primitive. Interface register codes on `acc_sel` are 0 = operand, 1 = instruction address and 2 = control. In the status register, bits 15:14 are the trace mode and bit 13 is the supervisor flag.

Top module: `cprs_resp_seq`

## Requirements
- R1: After reset `busy`, `acc_req`, `trace_pend`, `flush_req`, `exc_req`, `sr_load`, `pc_load` and `trace_take` are all 0.
- R2: A status transfer with direction 0 and scan-PC select 0 makes exactly one access: a write to the operand register (code 0) of the status register, zero-extended. It makes no flush.
- R3: A status transfer with direction 1 and scan-PC select 0 makes exactly one access, a read of the operand register. It then pulses `sr_load` for one cycle with the low 16 bits of the read data on `sr_new`.
- R4: A status transfer with direction 0 and scan-PC select 1 first writes the scan PC to the instruction-address register (code 1) and then writes the status register to the operand register.
- R5: A status transfer with direction 1 and scan-PC select 1 first reads the operand register into `sr_new` and then reads the instruction-address register into `pc_new`, pulsing `sr_load` and then `pc_load`.
- R6: Every status transfer with direction 1 raises a one-cycle `flush_req` in the cycle that `busy` falls. `flush_addr` is the newly read PC when the scan PC was transferred, and otherwise the scan PC captured at acceptance. `flush_super` is bit 13 of the newly loaded status register.
- R7: `trace_pend` is set only when a status transfer with direction 1 is accepted while `sr_in[15:14]` = 01. It stays set until `cp_done`, which produces a one-cycle `trace_take` and clears `trace_pend`.
- R8: Only the status register captured at acceptance decides trace arming. A loaded status register whose trace bits are 01 does not arm a trace for the current primitive.
- R9: The take-exception primitive writes 0x0001 to the control register (code 2). It then raises `exc_req` for exactly one cycle, with `exc_vec` equal to bits 7:0 of the primitive word.
- R10: When the PC flag is set, the first access of any primitive is a write of the scan PC to the instruction-address register.
- R11: Only one access is outstanding at a time. Its select, direction and write data stay unchanged until `acc_done`. `busy` is high from acceptance until the last access finishes, and a primitive offered while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prim_valid | input | 1 | Primitive offered |
| prim_exc | input | 1 | 1 = take-exception primitive, 0 = status transfer |
| prim_word | input | 16 | Primitive word |
| sr_in | input | 16 | Current status register |
| scan_pc | input | 32 | Current scan program counter |
| cp_done | input | 1 | Coprocessor reports instruction complete |
| acc_done | input | 1 | Current interface access finished |
| acc_rdata | input | 32 | Read data of the finishing access |
| busy | output | 1 | Primitive in progress |
| acc_req | output | 1 | Interface access request |
| acc_wr | output | 1 | 1 = write, 0 = read |
| acc_sel | output | 2 | Interface register code |
| acc_wdata | output | 32 | Write data |
| sr_load | output | 1 | One-cycle pulse: new status register valid |
| sr_new | output | 16 | Status register read from the coprocessor |
| pc_load | output | 1 | One-cycle pulse: new scan PC valid |
| pc_new | output | 32 | Scan PC read from the coprocessor |
| flush_req | output | 1 | One-cycle prefetch flush and refill request |
| flush_addr | output | 32 | Refill address |
| flush_super | output | 1 | Refill address space is supervisor |
| trace_pend | output | 1 | Change-of-flow trace pending |
| trace_take | output | 1 | One-cycle trace exception request |
| exc_req | output | 1 | One-cycle exception request |
| exc_vec | output | 8 | Exception vector number |

## Verification
On every cycle the assertions check the access handshake discipline, the acknowledge value written to the control register, and the single-cycle width of the exception request. They also check that a flush only appears as the primitive finishes and that each load pulse follows a matching read. The order of accesses for each combination of PC flag, direction and scan-PC select can only be shown by the bench's scenarios, which log every access. The same holds for the choice of refill address and address space, and for trace arming from the entry status register rather than the loaded one.

// File: rtl/cprs_pkg.sv
package cprs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PCPRE,
        ST_PCWR,
        ST_SRWR,
        ST_SRRD,
        ST_PCRD,
        ST_ACKWR
    } step_e;

    localparam logic [1:0] CIR_OPER  = 2'd0;
    localparam logic [1:0] CIR_IADDR = 2'd1;
    localparam logic [1:0] CIR_CTRL  = 2'd2;

    typedef struct packed {
        logic       pcb;
        logic       dir_in;
        logic       sp;
        logic       is_exc;
        logic [7:0] vec;
    } prim_s;

endpackage

// File: rtl/cprs_decode.sv
module cprs_decode
    import cprs_pkg::*;
#(
    parameter int W_W     = 16,
    parameter int PC_BIT  = 15,
    parameter int DIR_BIT = 13,
    parameter int SP_BIT  = 12
) (
    input  logic [W_W-1:0] word,
    input  logic           is_exc,
    output prim_s          prim
);
    logic unused_bits;

    assign unused_bits = ^{word[W_W-1:8]};

    always_comb begin
        prim.pcb    = word[PC_BIT];
        prim.is_exc = is_exc;
        // Direction and scan-PC select only matter for a status transfer.
        prim.dir_in = word[DIR_BIT] & ~is_exc;
        prim.sp     = word[SP_BIT] & ~is_exc;
        prim.vec    = word[7:0];
    end
endmodule

// File: rtl/cprs_order.sv
module cprs_order
    import cprs_pkg::*;
(
    input  step_e cur,
    input  prim_s prim,
    output step_e nxt
);
    step_e body;

    always_comb begin
        // First step after the optional PC-flag write.
        if (prim.is_exc)      body = ST_ACKWR;
        else if (prim.dir_in) body = ST_SRRD;
        else if (prim.sp)     body = ST_PCWR;
        else                  body = ST_SRWR;

        unique case (cur)
            ST_IDLE:  nxt = prim.pcb ? ST_PCPRE : body;
            ST_PCPRE: nxt = body;
            ST_PCWR:  nxt = ST_SRWR;
            ST_SRWR:  nxt = ST_IDLE;
            ST_SRRD:  nxt = prim.sp ? ST_PCRD : ST_IDLE;
            ST_PCRD:  nxt = ST_IDLE;
            ST_ACKWR: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/cprs_trace.sv
module cprs_trace (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic [1:0] tmode,
    input  logic       cp_done,
    output logic       pend,
    output logic       take
);
    typedef struct packed {
        logic pend;
        logic take;
    } tr_t;

    tr_t d, q;

    always_comb begin
        d      = q;
        d.take = q.pend & cp_done;
        if (arm && tmode == 2'b01) d.pend = 1'b1;
        else if (cp_done)          d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend = q.pend;
    assign take = q.take;
endmodule

// File: rtl/cprs_resp_seq.sv
module cprs_resp_seq
    import cprs_pkg::*;
#(
    parameter int          SR_W      = 16,
    parameter int          PC_W      = 32,
    parameter int          VEC_W     = 8,
    parameter int          SUPER_BIT = 13,
    parameter int          TRACE_HI  = 15,
    parameter int unsigned ACK_MASK  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prim_valid,
    input  logic             prim_exc,
    input  logic [15:0]      prim_word,
    input  logic [SR_W-1:0]  sr_in,
    input  logic [PC_W-1:0]  scan_pc,
    input  logic             cp_done,
    input  logic             acc_done,
    input  logic [PC_W-1:0]  acc_rdata,
    output logic             busy,
    output logic             acc_req,
    output logic             acc_wr,
    output logic [1:0]       acc_sel,
    output logic [PC_W-1:0]  acc_wdata,
    output logic             sr_load,
    output logic [SR_W-1:0]  sr_new,
    output logic             pc_load,
    output logic [PC_W-1:0]  pc_new,
    output logic             flush_req,
    output logic [PC_W-1:0]  flush_addr,
    output logic             flush_super,
    output logic             trace_pend,
    output logic             trace_take,
    output logic             exc_req,
    output logic [VEC_W-1:0] exc_vec
);
    typedef struct packed {
        step_e             step;
        prim_s             prim;
        logic [SR_W-1:0]   sr_snap;
        logic [PC_W-1:0]   pc_snap;
        logic [SR_W-1:0]   sr_new;
        logic [PC_W-1:0]   pc_new;
        logic              sr_load;
        logic              pc_load;
        logic              flush;
        logic [PC_W-1:0]   flush_addr;
        logic              flush_super;
        logic              exc;
        logic [VEC_W-1:0]  exc_vec;
    } ctx_t;

    ctx_t  d, q;
    prim_s dec_prim;
    prim_s ord_prim;
    step_e nxt_step;
    logic  accept;
    logic  arm;

    cprs_decode u_dec (
        .word   (prim_word),
        .is_exc (prim_exc),
        .prim   (dec_prim)
    );

    assign ord_prim = (q.step == ST_IDLE) ? dec_prim : q.prim;

    cprs_order u_ord (
        .cur  (q.step),
        .prim (ord_prim),
        .nxt  (nxt_step)
    );

    assign accept = prim_valid && (q.step == ST_IDLE);
    assign arm    = accept && dec_prim.dir_in;

    cprs_trace u_trc (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .tmode   (sr_in[TRACE_HI -: 2]),
        .cp_done (cp_done),
        .pend    (trace_pend),
        .take    (trace_take)
    );

    always_comb begin
        d         = q;
        d.sr_load = 1'b0;
        d.pc_load = 1'b0;
        d.flush   = 1'b0;
        d.exc     = 1'b0;
        if (accept) begin
            d.prim    = dec_prim;
            d.sr_snap = sr_in;
            d.pc_snap = scan_pc;
            d.step    = nxt_step;
        end else if (q.step != ST_IDLE && acc_done) begin
            if (q.step == ST_SRRD) begin
                d.sr_new  = acc_rdata[SR_W-1:0];
                d.sr_load = 1'b1;
            end
            if (q.step == ST_PCRD) begin
                d.pc_new  = acc_rdata;
                d.pc_load = 1'b1;
            end
            d.step = nxt_step;
            if (nxt_step == ST_IDLE) begin
                if (q.prim.is_exc) begin
                    d.exc     = 1'b1;
                    d.exc_vec = q.prim.vec[VEC_W-1:0];
                end else if (q.prim.dir_in) begin
                    d.flush       = 1'b1;
                    d.flush_addr  = (q.step == ST_PCRD) ? acc_rdata : q.pc_snap;
                    d.flush_super = (q.step == ST_SRRD) ? acc_rdata[SUPER_BIT]
                                                        : q.sr_new[SUPER_BIT];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        acc_req   = (q.step != ST_IDLE);
        acc_wr    = 1'b1;
        acc_sel   = CIR_OPER;
        acc_wdata = '0;
        unique case (q.step)
            ST_PCPRE, ST_PCWR: begin
                acc_sel   = CIR_IADDR;
                acc_wdata = q.pc_snap;
            end
            ST_SRWR: acc_wdata = PC_W'(q.sr_snap);
            ST_SRRD: acc_wr = 1'b0;
            ST_PCRD: begin
                acc_wr  = 1'b0;
                acc_sel = CIR_IADDR;
            end
            ST_ACKWR: begin
                acc_sel   = CIR_CTRL;
                acc_wdata = PC_W'(ACK_MASK);
            end
            default: ;
        endcase
    end

    assign busy        = (q.step != ST_IDLE);
    assign sr_load     = q.sr_load;
    assign sr_new      = q.sr_new;
    assign pc_load     = q.pc_load;
    assign pc_new      = q.pc_new;
    assign flush_req   = q.flush;
    assign flush_addr  = q.flush_addr;
    assign flush_super = q.flush_super;
    assign exc_req     = q.exc;
    assign exc_vec     = q.exc_vec;
endmodule

// File: rtl/cprs_resp_seq_chk.sv
module cprs_resp_seq_chk #(
    parameter int          PC_W     = 32,
    parameter int unsigned ACK_MASK = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            acc_req,
    input logic            acc_done,
    input logic            acc_wr,
    input logic [1:0]      acc_sel,
    input logic [PC_W-1:0] acc_wdata,
    input logic            exc_req,
    input logic            flush_req,
    input logic            sr_load,
    input logic            pc_load
);
    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |-> busy); // R11
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !acc_done |=> acc_req && $stable(acc_sel) && $stable(acc_wr)
                                 && $stable(acc_wdata)); // R11
    AST_ACK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_sel == 2'd2 |-> acc_wr && acc_wdata == PC_W'(ACK_MASK)); // R9
    AST_EXC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> !exc_req); // R9
    AST_FLUSH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !busy && !exc_req); // R6
    AST_SR_LOAD_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sr_load |-> $past(acc_req && acc_done && !acc_wr && acc_sel == 2'd0)); // R3
    AST_PC_LOAD_READ: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> $past(acc_req && acc_done && !acc_wr && acc_sel == 2'd1)); // R5
endmodule

bind cprs_resp_seq cprs_resp_seq_chk #(.PC_W(PC_W), .ACK_MASK(ACK_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .acc_req   (acc_req),
    .acc_done  (acc_done),
    .acc_wr    (acc_wr),
    .acc_sel   (acc_sel),
    .acc_wdata (acc_wdata),
    .exc_req   (exc_req),
    .flush_req (flush_req),
    .sr_load   (sr_load),
    .pc_load   (pc_load)
);

// File: tb/sim_cprs_resp_seq.sv
`timescale 1ns/1ps
module sim_cprs_resp_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prim_valid = 1'b0;
    logic        prim_exc = 1'b0;
    logic [15:0] prim_word = '0;
    logic [15:0] sr_in = '0;
    logic [31:0] scan_pc = '0;
    logic        cp_done = 1'b0;
    logic        acc_done = 1'b0;
    logic [31:0] acc_rdata = '0;
    logic        busy, acc_req, acc_wr;
    logic [1:0]  acc_sel;
    logic [31:0] acc_wdata;
    logic        sr_load, pc_load, flush_req, flush_super;
    logic [15:0] sr_new;
    logic [31:0] pc_new, flush_addr;
    logic        trace_pend, trace_take, exc_req;
    logic [7:0]  exc_vec;

    cprs_resp_seq u0 (.*);

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int lat = 1;
    int wait_n = 0;
    int req_cycles = 0;
    int n_log = 0;
    logic [1:0]  log_sel [16];
    logic        log_wr  [16];
    logic [31:0] log_wd  [16];
    logic [15:0] rd_oper = '0;
    logic [31:0] rd_iaddr = '0;
    int n_sr = 0, n_pc = 0, n_fl = 0, n_exc = 0, n_take = 0;
    logic [15:0] last_sr;
    logic [31:0] last_pc, last_fa;
    logic        last_fs;
    logic [7:0]  last_vec;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Interface responder: answers each access after lat cycles.
    initial begin
        forever begin
            @(negedge clk);
            acc_done = 1'b0;
            if (acc_req) begin
                req_cycles++;
                if (wait_n >= lat - 1) begin
                    wait_n = 0;
                    acc_done = 1'b1;
                    acc_rdata = (acc_sel == 2'd1) ? rd_iaddr : {16'h0, rd_oper};
                    if (n_log < 16) begin
                        log_sel[n_log] = acc_sel;
                        log_wr[n_log]  = acc_wr;
                        log_wd[n_log]  = acc_wdata;
                    end
                    n_log++;
                end else begin
                    wait_n++;
                end
            end
        end
    end

    // Pulse monitor.
    initial begin
        forever begin
            @(negedge clk);
            if (sr_load)    begin n_sr++;   last_sr = sr_new; end
            if (pc_load)    begin n_pc++;   last_pc = pc_new; end
            if (flush_req)  begin n_fl++;   last_fa = flush_addr; last_fs = flush_super; end
            if (exc_req)    begin n_exc++;  last_vec = exc_vec; end
            if (trace_take) n_take++;
        end
    end

    task automatic clear_logs();
        n_log = 0; n_sr = 0; n_pc = 0; n_fl = 0; n_exc = 0; n_take = 0;
        req_cycles = 0;
    endtask

    task automatic run_prim(input bit exc, input logic [15:0] w);
        clear_logs();
        @(negedge clk);
        prim_exc = exc; prim_word = w; prim_valid = 1'b1;
        @(negedge clk);
        prim_valid = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic chk_acc(input int i, input string req, input logic [1:0] sel,
                           input bit wr, input logic [31:0] wd);
        chk(log_sel[i] == sel, req, 32'(log_sel[i]), 32'(sel));
        chk(log_wr[i] == wr, req, 32'(log_wr[i]), 32'(wr));
        if (wr) chk(log_wd[i] == wd, req, log_wd[i], wd);
    endtask

    task automatic t_reset();
        chk(!busy && !acc_req && !trace_pend, "R1 idle", {busy, acc_req, trace_pend}, 0);
        chk(!flush_req && !exc_req && !sr_load && !pc_load && !trace_take, "R1 pulses",
            {flush_req, exc_req, sr_load, pc_load, trace_take}, 0);
    endtask

    task automatic t_sr_out();
        sr_in = 16'h2715; scan_pc = 32'h1000;
        run_prim(1'b0, 16'h0000);
        chk(n_log == 1, "R2 count", n_log, 1);
        chk_acc(0, "R2 oper write", 2'd0, 1'b1, 32'h2715);
        chk(n_fl == 0, "R2 no flush", n_fl, 0);
    endtask

    task automatic t_sr_in();
        sr_in = 16'h0000; scan_pc = 32'h1000; rd_oper = 16'h2005;
        run_prim(1'b0, 16'h2000);
        chk(n_log == 1, "R3 count", n_log, 1);
        chk_acc(0, "R3 oper read", 2'd0, 1'b0, 0);
        chk(n_sr == 1 && last_sr == 16'h2005, "R3 sr_new", last_sr, 16'h2005);
        chk(n_fl == 1 && last_fa == 32'h1000, "R6 flush addr", last_fa, 32'h1000);
        chk(last_fs == 1'b1, "R6 super", 32'(last_fs), 1);
    endtask

    task automatic t_both_out();
        sr_in = 16'h0310; scan_pc = 32'h4A20;
        run_prim(1'b0, 16'h1000);
        chk(n_log == 2, "R4 count", n_log, 2);
        chk_acc(0, "R4 pc first", 2'd1, 1'b1, 32'h4A20);
        chk_acc(1, "R4 sr second", 2'd0, 1'b1, 32'h0310);
    endtask

    task automatic t_both_in();
        sr_in = 16'h0000; scan_pc = 32'h1234; rd_oper = 16'h0004; rd_iaddr = 32'h8800;
        lat = 2;
        run_prim(1'b0, 16'h3000);
        lat = 1;
        chk(n_log == 2, "R5 count", n_log, 2);
        chk_acc(0, "R5 sr read first", 2'd0, 1'b0, 0);
        chk_acc(1, "R5 pc read second", 2'd1, 1'b0, 0);
        chk(n_sr == 1 && last_sr == 16'h0004, "R5 sr_new", last_sr, 16'h0004);
        chk(n_pc == 1 && last_pc == 32'h8800, "R5 pc_new", last_pc, 32'h8800);
        chk(n_fl == 1 && last_fa == 32'h8800, "R6 flush new pc", last_fa, 32'h8800);
        chk(last_fs == 1'b0, "R6 user space", 32'(last_fs), 0);
    endtask

    task automatic t_trace();
        sr_in = 16'h4000; rd_oper = 16'h0000;
        run_prim(1'b0, 16'h2000);
        chk(trace_pend == 1'b1, "R7 armed", 32'(trace_pend), 1);
        chk(n_take == 0, "R7 waits for done", n_take, 0);
        @(negedge clk); cp_done = 1'b1;
        @(negedge clk); cp_done = 1'b0;
        @(negedge clk);
        chk(n_take == 1, "R7 take", n_take, 1);
        chk(trace_pend == 1'b0, "R7 cleared", 32'(trace_pend), 0);
        sr_in = 16'h4000;
        run_prim(1'b0, 16'h0000);
        chk(trace_pend == 1'b0, "R7 outbound no arm", 32'(trace_pend), 0);
    endtask

    task automatic t_trace_new();
        sr_in = 16'h0000; rd_oper = 16'h4000;
        run_prim(1'b0, 16'h2000);
        chk(n_sr == 1 && last_sr == 16'h4000, "R8 loaded", last_sr, 16'h4000);
        chk(trace_pend == 1'b0, "R8 no arm from new sr", 32'(trace_pend), 0);
    endtask

    task automatic t_exc();
        run_prim(1'b1, 16'h003C);
        chk(n_log == 1, "R9 count", n_log, 1);
        chk_acc(0, "R9 ack write", 2'd2, 1'b1, 32'h0001);
        chk(n_exc == 1 && last_vec == 8'h3C, "R9 vector", last_vec, 8'h3C);
        chk(n_fl == 0, "R9 no flush", n_fl, 0);
    endtask

    task automatic t_pcbit();
        scan_pc = 32'hBEEF0; sr_in = 16'h0055;
        run_prim(1'b1, 16'h8081);
        chk(n_log == 2, "R10 exc count", n_log, 2);
        chk_acc(0, "R10 pc first", 2'd1, 1'b1, 32'hBEEF0);
        chk_acc(1, "R10 ack after", 2'd2, 1'b1, 32'h0001);
        chk(n_exc == 1 && last_vec == 8'h81, "R10 vector", last_vec, 8'h81);
        run_prim(1'b0, 16'h8000);
        chk(n_log == 2, "R10 xfer count", n_log, 2);
        chk_acc(0, "R10 xfer pc first", 2'd1, 1'b1, 32'hBEEF0);
        chk_acc(1, "R10 xfer sr", 2'd0, 1'b1, 32'h0055);
    endtask

    task automatic t_busy_ignore();
        sr_in = 16'h0123; lat = 3;
        clear_logs();
        @(negedge clk);
        prim_exc = 1'b0; prim_word = 16'h0000; prim_valid = 1'b1;
        @(negedge clk);
        prim_exc = 1'b1; prim_word = 16'h0077;
        chk(busy == 1'b1, "R11 busy", 32'(busy), 1);
        @(negedge clk);
        prim_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        lat = 1;
        chk(n_log == 1, "R11 one access", n_log, 1);
        chk(req_cycles == 3, "R11 held until done", req_cycles, 3);
        chk(n_exc == 0, "R11 ignored while busy", n_exc, 0);
        chk(!busy, "R11 idle after", 32'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_sr_out();
        t_sr_in();
        t_both_out();
        t_both_in();
        t_trace();
        t_trace_new();
        t_exc();
        t_pcbit();
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule